// File: doc/BRIEF.md
# Vector Structure Load-Store Address Generator

This block turns the operands of a vector structure load or store into the address that goes to memory, and into the new value of the base register. It takes the base register value and an addressing mode. The mode is one of three: no writeback, writeback with a 64-bit index register added, or writeback with an immediate added. It also takes the element size, the total number of bytes the instruction moves, a flag that tells whether the instruction is a multiple-structure form or a single-structure/replicate form, and a strict-alignment enable.

The memory access always uses the base as it arrives. Any increment changes only the written-back base. An immediate increment is not a free offset. It must equal the number of bytes moved, and it must also belong to the set of values the instruction form allows. When strict alignment is on, the base must be a multiple of the element size. The total transfer size plays no part in that check. Either fault blocks the writeback.

Results are registered. They appear one clock after a valid input, with `out_valid` marking them. The block does not touch memory or the register file.

Top module: `vlsag_top`

## Requirements
- R1: Mode encoding on `mode` is: 0 = base only, 1 = post-increment by `index_in`, 2 = post-increment by `imm_in`, 3 = treated as base only. Every input presented with `in_valid` high produces exactly one result with `out_valid` high on the next clock edge. `out_valid` is low otherwise.
- R2: `addr_out` equals the presented `base_in` in every mode, whether or not a fault is raised.
- R3: In base-only modes (0 and 3), `wb_en` is low, `wb_base` equals `base_in`, and `imm_illegal` is low whatever `imm_in` and `xfer_bytes` hold.
- R4: In index mode, `wb_base` is `base_in + index_in` modulo 2^64, so a carry out of bit 63 wraps. `wb_en` is high unless a fault is raised.
- R5: In immediate mode, `wb_base` is `base_in + imm_in` with `imm_in` zero-extended. `wb_en` is high unless a fault is raised. `wb_base` holds the sum even when a fault is raised.
- R6: In immediate mode, `imm_illegal` is raised whenever `imm_in` differs from `xfer_bytes`.
- R7: With `multi_form` = 1, an immediate is legal only if it is one of 8, 16, 24, 32, 48 or 64. Any other value raises `imm_illegal`, even when it equals `xfer_bytes`.
- R8: With `multi_form` = 0, an immediate is legal only if it is one of 1, 2, 3, 4, 6, 8, 12, 16, 24 or 32. Any other value raises `imm_illegal`, even when it equals `xfer_bytes`.
- R9: `elem_size` codes 0..3 mean 1, 2, 4 or 8 bytes. With `strict_align` high, `align_fault` is raised when `base_in` is not a multiple of the element size. With `strict_align` low, `align_fault` is never raised.
- R10: Alignment is judged against the element size only. A base aligned to the element size but not to `xfer_bytes` raises no fault.
- R11: When either `align_fault` or `imm_illegal` is raised, `wb_en` is low.
- R12: While reset is asserted, `out_valid`, `wb_en`, `align_fault`, `imm_illegal`, `addr_out` and `wb_base` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| mode | input | 2 | Addressing mode (R1 encoding) |
| base_in | input | 64 | Base register value |
| index_in | input | 64 | Index register value for mode 1 |
| imm_in | input | 8 | Post-increment immediate for mode 2 |
| multi_form | input | 1 | 1 = multiple-structure form, 0 = single/replicate form |
| elem_size | input | 2 | log2 of element size in bytes |
| xfer_bytes | input | 8 | Total bytes moved by the instruction |
| strict_align | input | 1 | Strict alignment checking enable |
| out_valid | output | 1 | Result valid |
| addr_out | output | 64 | Memory access address |
| wb_base | output | 64 | Updated base value |
| wb_en | output | 1 | Base writeback enable |
| align_fault | output | 1 | Alignment fault |
| imm_illegal | output | 1 | Illegal post-increment immediate |

## Verification
The hardest cases to reach are immediates that equal the transfer size but fall outside the set allowed for the form. Examples are 12 in a multiple-structure form, or 64 in a single form. A bench that only feeds matching pairs never hits these. So the stimulus sweeps every immediate from 0 to 70, in both forms, with `xfer_bytes` tied to the immediate, and adds deliberate mismatches on top. Writeback suppression by an alignment fault needs strict mode and a misaligned base together with an otherwise legal post-increment. Index wraparound needs a base near the top of the 64-bit space. The stimulus builds both of these situations directly.

// File: rtl/vlsag_pkg.sv
package vlsag_pkg;

  typedef enum logic [1:0] {
    AM_BASE  = 2'd0,
    AM_INDEX = 2'd1,
    AM_IMM   = 2'd2,
    AM_RSVD  = 2'd3
  } amode_e;

  // Allowed post-increment values per instruction form
  function automatic logic imm_in_set(input logic multi, input logic [7:0] v);
    if (multi)
      return (v == 8'd8)  || (v == 8'd16) || (v == 8'd24) ||
             (v == 8'd32) || (v == 8'd48) || (v == 8'd64);
    else
      return (v == 8'd1)  || (v == 8'd2)  || (v == 8'd3)  || (v == 8'd4) ||
             (v == 8'd6)  || (v == 8'd8)  || (v == 8'd12) || (v == 8'd16) ||
             (v == 8'd24) || (v == 8'd32);
  endfunction

  // Low-order address bits that must be zero for a given element size code
  function automatic logic [7:0] elem_mask(input logic [1:0] es);
    return (8'd1 << es) - 8'd1;
  endfunction

endpackage

// File: rtl/vlsag_incr.sv
module vlsag_incr #(
  parameter int ADDR_W = 64,
  parameter int IMM_W  = 8
) (
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] index,
  input  logic [IMM_W-1:0]  imm,
  output logic [ADDR_W-1:0] next_base,
  output logic              does_wb
);
  import vlsag_pkg::*;

  logic [ADDR_W-1:0] step;

  always_comb begin
    step    = '0;
    does_wb = 1'b0;
    case (amode_e'(mode))
      AM_INDEX: begin step = index; does_wb = 1'b1; end
      AM_IMM:   begin step = {{(ADDR_W-IMM_W){1'b0}}, imm}; does_wb = 1'b1; end
      default:  begin step = '0; does_wb = 1'b0; end
    endcase
    next_base = base + step;
  end
endmodule

// File: rtl/vlsag_imm_chk.sv
module vlsag_imm_chk #(
  parameter int IMM_W = 8
) (
  input  logic             is_imm_mode,
  input  logic             multi,
  input  logic [IMM_W-1:0] imm,
  input  logic [IMM_W-1:0] xfer,
  output logic             illegal
);
  import vlsag_pkg::*;

  logic mismatch;
  logic off_set;

  always_comb begin
    mismatch = (imm != xfer);
    off_set  = !imm_in_set(multi, 8'(imm));
    illegal  = is_imm_mode && (mismatch || off_set);
  end
endmodule

// File: rtl/vlsag_align_chk.sv
module vlsag_align_chk #(
  parameter int ADDR_W = 64,
  parameter int ESZ_W  = 2
) (
  input  logic              strict,
  input  logic [ESZ_W-1:0]  es,
  input  logic [ADDR_W-1:0] base,
  output logic              fault
);
  import vlsag_pkg::*;

  logic [7:0] mask;

  always_comb begin
    mask  = elem_mask(2'(es));
    fault = strict && ((base[7:0] & mask) != 8'd0);
  end
endmodule

// File: rtl/vlsag_top.sv
module vlsag_top #(
  parameter int ADDR_W = 64,
  parameter int IMM_W  = 8,
  parameter int ESZ_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [ADDR_W-1:0] index_in,
  input  logic [IMM_W-1:0]  imm_in,
  input  logic              multi_form,
  input  logic [ESZ_W-1:0]  elem_size,
  input  logic [IMM_W-1:0]  xfer_bytes,
  input  logic              strict_align,
  output logic              out_valid,
  output logic [ADDR_W-1:0] addr_out,
  output logic [ADDR_W-1:0] wb_base,
  output logic              wb_en,
  output logic              align_fault,
  output logic              imm_illegal
);
  import vlsag_pkg::*;

  logic [ADDR_W-1:0] next_base_w;
  logic              does_wb_w;
  logic              imm_bad_w;
  logic              misalign_w;
  logic              any_fault_w;
  logic              is_imm_w;

  assign is_imm_w    = (mode == 2'(AM_IMM));
  assign any_fault_w = imm_bad_w || misalign_w;

  vlsag_incr #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_incr (
    .mode      (mode),
    .base      (base_in),
    .index     (index_in),
    .imm       (imm_in),
    .next_base (next_base_w),
    .does_wb   (does_wb_w)
  );

  vlsag_imm_chk #(.IMM_W(IMM_W)) u_imm (
    .is_imm_mode (is_imm_w),
    .multi       (multi_form),
    .imm         (imm_in),
    .xfer        (xfer_bytes),
    .illegal     (imm_bad_w)
  );

  vlsag_align_chk #(.ADDR_W(ADDR_W), .ESZ_W(ESZ_W)) u_align (
    .strict (strict_align),
    .es     (elem_size),
    .base   (base_in),
    .fault  (misalign_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      addr_out    <= '0;
      wb_base     <= '0;
      wb_en       <= 1'b0;
      align_fault <= 1'b0;
      imm_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        addr_out    <= base_in;
        wb_base     <= next_base_w;
        wb_en       <= does_wb_w && !any_fault_w;
        align_fault <= misalign_w;
        imm_illegal <= imm_bad_w;
      end else begin
        wb_en       <= 1'b0;
        align_fault <= 1'b0;
        imm_illegal <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vlsag_checker.sv
module vlsag_checker #(
  parameter int ADDR_W = 64,
  parameter int IMM_W  = 8,
  parameter int ESZ_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        mode,
  input logic [ADDR_W-1:0] base_in,
  input logic [ADDR_W-1:0] index_in,
  input logic [IMM_W-1:0]  imm_in,
  input logic              strict_align,
  input logic [ESZ_W-1:0]  elem_size,
  input logic              out_valid,
  input logic [ADDR_W-1:0] addr_out,
  input logic [ADDR_W-1:0] wb_base,
  input logic              wb_en,
  input logic              align_fault,
  input logic              imm_illegal,
  input logic [IMM_W-1:0]  xfer_bytes
);

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  addr_is_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> addr_out == $past(base_in));

  // R3
  base_only_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mode == 2'd0 || mode == 2'd3)) |=> (!wb_en && !imm_illegal));

  // R4
  index_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd1) |=> wb_base == $past(base_in) + $past(index_in));

  // R6
  imm_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd2 && imm_in != xfer_bytes) |=> imm_illegal);

  // R9
  relaxed_nofault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !strict_align) |=> !align_fault);

  // R10
  byte_elem_nofault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && elem_size == '0) |=> !align_fault);

  // R11
  fault_blocks_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (align_fault || imm_illegal) |-> !wb_en);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!wb_en && !align_fault && !imm_illegal));

endmodule

bind vlsag_top vlsag_checker #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .ESZ_W(ESZ_W)) u_vlsag_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .mode         (mode),
  .base_in      (base_in),
  .index_in     (index_in),
  .imm_in       (imm_in),
  .strict_align (strict_align),
  .elem_size    (elem_size),
  .out_valid    (out_valid),
  .addr_out     (addr_out),
  .wb_base      (wb_base),
  .wb_en        (wb_en),
  .align_fault  (align_fault),
  .imm_illegal  (imm_illegal),
  .xfer_bytes   (xfer_bytes)
);

// File: tb/test_vlsag_top.sv
`timescale 1ns/1ps
module test_vlsag_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  mode = '0;
  logic [63:0] base_in = '0;
  logic [63:0] index_in = '0;
  logic [7:0]  imm_in = '0;
  logic        multi_form = 1'b0;
  logic [1:0]  elem_size = '0;
  logic [7:0]  xfer_bytes = '0;
  logic        strict_align = 1'b0;
  logic        out_valid;
  logic [63:0] addr_out;
  logic [63:0] wb_base;
  logic        wb_en;
  logic        align_fault;
  logic        imm_illegal;

  always #2.5 clk = ~clk;

  vlsag_top i_vlsag_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .base_in(base_in), .index_in(index_in), .imm_in(imm_in),
    .multi_form(multi_form), .elem_size(elem_size), .xfer_bytes(xfer_bytes),
    .strict_align(strict_align), .out_valid(out_valid), .addr_out(addr_out),
    .wb_base(wb_base), .wb_en(wb_en), .align_fault(align_fault),
    .imm_illegal(imm_illegal)
  );

  typedef struct packed {
    logic [63:0] addr;
    logic [63:0] wbb;
    logic        wbe;
    logic        af;
    logic        il;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;

  task automatic check64(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Legal immediate sets written as tables, independent of any arithmetic
  function automatic bit legal_imm(input bit multi, input int v);
    int mset[6]  = '{8, 16, 24, 32, 48, 64};
    int sset[10] = '{1, 2, 3, 4, 6, 8, 12, 16, 24, 32};
    if (multi) begin
      foreach (mset[k]) if (mset[k] == v) return 1'b1;
    end else begin
      foreach (sset[k]) if (sset[k] == v) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic drive(input string tag, input int md, input logic [63:0] b,
                       input logic [63:0] ix, input int im, input bit mf,
                       input int es, input int xb, input bit st);
    exp_t e;
    longint unsigned ebytes;
    ebytes = longint'(1) << es;
    e.addr = b;
    e.af   = st && ((b % ebytes) != 0);
    e.il   = (md == 2) && ((im != xb) || !legal_imm(mf, im));
    case (md)
      1:       e.wbb = b + ix;
      2:       e.wbb = b + 64'(im);
      default: e.wbb = b;
    endcase
    e.wbe = (md == 1 || md == 2) && !e.af && !e.il;
    @(negedge clk);
    in_valid     = 1'b1;
    mode         = 2'(md);
    base_in      = b;
    index_in     = ix;
    imm_in       = 8'(im);
    multi_form   = mf;
    elem_size    = 2'(es);
    xfer_bytes   = 8'(xb);
    strict_align = st;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      imm_in   = 8'hA5;
      mode     = 2'd2;
    end
  endtask

  // Monitor: compares results against the queued expectations
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (exp_q.size() == 0) begin
          checks++; failures++;
          $display("FAIL R1 out_valid actual=1 expected=0");
        end else begin
          exp_t  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check64({t, "/R2"}, "addr_out", addr_out, e.addr);
          check64(t, "wb_base", wb_base, e.wbb);
          check64({t, "/R11"}, "wb_en", 64'(wb_en), 64'(e.wbe));
          check64(t, "align_fault", 64'(align_fault), 64'(e.af));
          check64(t, "imm_illegal", 64'(imm_illegal), 64'(e.il));
        end
      end else if (rst_n && exp_q.size() != 0) begin
        checks++; failures++;
        $display("FAIL R1 out_valid actual=0 expected=1");
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: outputs held at zero in reset
    check64("R12", "out_valid", 64'(out_valid), 64'd0);
    check64("R12", "wb_en", 64'(wb_en), 64'd0);
    check64("R12", "flags", {62'd0, align_fault, imm_illegal}, 64'd0);
    check64("R12", "addr_out", addr_out, 64'd0);
    check64("R12", "wb_base", wb_base, 64'd0);
    rst_n = 1'b1;
    idle(2);

    // R3: base-only, mismatched immediate ignored
    drive("R3", 0, 64'h1000, 64'h55, 7, 1'b1, 3, 40, 1'b0);
    drive("R3", 3, 64'h2000, 64'h55, 9, 1'b0, 0, 2, 1'b0);
    // R4: index post-increment, wraparound, negative index
    drive("R4", 1, 64'h1000, 64'h20, 0, 1'b1, 2, 16, 1'b0);
    drive("R4", 1, 64'hFFFF_FFFF_FFFF_FFF0, 64'h20, 0, 1'b1, 0, 8, 1'b0);
    drive("R4", 1, 64'h1000, -64'sd16, 0, 1'b0, 1, 2, 1'b0);
    idle(1);
    // R5/R6: immediate legal and mismatched
    drive("R5", 2, 64'h3000, 64'h0, 32, 1'b1, 2, 32, 1'b0);
    drive("R6", 2, 64'h3000, 64'h0, 32, 1'b1, 2, 16, 1'b0);
    drive("R5", 2, 64'h3000, 64'h0, 12, 1'b0, 2, 12, 1'b0);
    // R7/R8: equal to transfer but outside the form's set
    drive("R7", 2, 64'h3000, 64'h0, 12, 1'b1, 2, 12, 1'b0);
    drive("R8", 2, 64'h3000, 64'h0, 64, 1'b0, 3, 64, 1'b0);
    idle(2);
    // R9: strict alignment per element size
    drive("R9", 1, 64'h1002, 64'h10, 0, 1'b1, 2, 16, 1'b1);
    drive("R9", 1, 64'h1002, 64'h10, 0, 1'b1, 2, 16, 1'b0);
    drive("R9", 2, 64'h1008, 64'h0, 16, 1'b1, 3, 16, 1'b1);
    drive("R9", 2, 64'h1004, 64'h0, 16, 1'b1, 3, 16, 1'b1);
    drive("R9", 0, 64'h1001, 64'h0, 0, 1'b0, 1, 2, 1'b1);
    // R10: element aligned but not transfer-size aligned
    drive("R10", 2, 64'h1001, 64'h0, 16, 1'b1, 0, 16, 1'b1);
    drive("R10", 1, 64'h1004, 64'h8, 0, 1'b1, 2, 64, 1'b1);
    // R11: both faults together
    drive("R11", 2, 64'h1003, 64'h0, 5, 1'b0, 1, 6, 1'b1);
    idle(1);
    // R7/R8 sweep of every immediate with matching transfer size
    for (int v = 0; v <= 70; v++) begin
      drive("R7", 2, 64'h4000 + 64'(v), 64'h0, v, 1'b1, 0, v, 1'b0);
      drive("R8", 2, 64'h8000 + 64'(v), 64'h0, v, 1'b0, 0, v, 1'b0);
    end
    idle(4);
    check64("R1", "queue_empty", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule